// File: doc/BRIEF.md
# Serial Register-Space Target with Clock Snapshot Hold

This block is an I2C target that opens a 64-byte register space to a bus controller. The space holds a user-visible copy of eight timekeeping bytes at the bottom, then control bytes and general RAM. SDA and SCL come in as oversampled levels and are synchronised to the system clock. The block finds START, STOP and repeated START conditions, decodes the address byte, and then handles a pointer byte followed by sequential writes, or a run of sequential reads. It pulls SDA low through an open-drain enable.

A timekeeping core outside this block offers a fresh eight-byte time value with `upd_valid`. The block takes that value into its copy unless the controller is working inside the clock range. Then `snap_hold` freezes the copy, so a multi-byte read returns one consistent instant. A write into the clock range is passed to the core as a one-cycle set pulse. The core uses this pulse to reload the field and to restart its divider chain. The sub-second byte only ever takes the value 00h. A power-fail input stops all bus activity at once.

Top module: `rtc_i2c_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 68h (D0h write, D1h read) by holding `sda_oe` high during the ninth clock. For any other address it leaves `sda_oe` low and ignores the bus until the next START.
- R2: After a write address, the first byte loads the 6-bit pointer. Every later byte is stored at the pointer. The block acknowledges the pointer byte and every data byte.
- R3: The pointer steps by one on the ninth (acknowledge) clock after each data byte, in both writes and reads. It wraps from 3Fh to 00h.
- R4: A read that is not preceded by a pointer write starts at the pointer value left by the previous transfer.
- R5: `snap_hold` is high while the block is selected and the pointer is below 08h. It falls on STOP, or as soon as the pointer reaches 08h or above. While it is high, `upd_valid` does not change the stored clock bytes.
- R6: A data write to address 00h..07h produces one `set_we` pulse carrying `set_addr` (pointer bits 2:0) and `set_data`. It also forces byte 00h to 00h. A write to address 00h always stores and reports 00h, whatever value was sent.
- R7: In a read, a NACK from the controller ends the transfer. `sda_oe` stays low until the next START.
- R8: While `pwr_fail` is high, the block drops `sda_oe` and `snap_hold` on the next cycle and resets the pointer to 00h. It acknowledges nothing while the input stays high.
- R9: Read data go out MSB first. `sda_oe` changes only while the synchronised SCL is low, so the data line is stable throughout every SCL-high period.
- R10: After reset, `sda_oe`, `snap_hold` and `set_we` are low and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| pwr_fail | input | 1 | Supply-fail indication; aborts and blocks the bus |
| upd_valid | input | 1 | Fresh time value offered by the timekeeping core |
| upd_time | input | 64 | Time value, byte n in bits 8n+7:8n |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| snap_hold | output | 1 | Tells the core its visible copy is frozen |
| set_we | output | 1 | One-cycle pulse: clock field written, restart divider |
| set_addr | output | 3 | Clock byte index written |
| set_data | output | 8 | Value written (00h for byte 0) |

## Verification
A level on the bus pins reaches the edge detector after the two synchroniser flops and one edge register. Each response on `sda_oe` therefore appears three to four system cycles after the SCL edge that causes it. The bench holds every SCL phase for eight cycles and samples the data line in the middle of the high phase and again just before the fall. `snap_hold` follows the registered pointer one cycle after the change. The bench checks it a quarter-bit after the STOP or acknowledge clock. A `set_we` pulse comes one cycle after the eighth falling edge of a data byte. A monitor pops the expected address/data pair from a queue on each pulse, so a missing, extra or reordered pulse is caught whenever it happens.

// File: rtl/rtc_i2c_target.sv
module rtc_i2c_target #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int AW = 6,
  parameter int NCLK = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 pwr_fail,
  input  logic                 upd_valid,
  input  logic [NCLK*8-1:0]    upd_time,
  output logic                 sda_oe,
  output logic                 snap_hold,
  output logic                 set_we,
  output logic [$clog2(NCLK)-1:0] set_addr,
  output logic [7:0]           set_data
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(NCLK);
  localparam logic [AW-1:0] CLK_END = AW'(NCLK);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_PTR, S_PACK, S_WR, S_WACK, S_RD, S_RACK
  } state_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [7:0] mem [DEPTH];
  state_t     state;
  logic [7:0] sreg, tx;
  logic [3:0] bitcnt;
  logic [AW-1:0] ptr;
  logic       rw, sel, mack;

  wire scl     = scl_sy[1];
  wire sda     = sda_sy[1];
  wire start_c = scl & scl_q & sda_q & ~sda;
  wire stop_c  = scl & scl_q & ~sda_q & sda;
  wire rise    = scl & ~scl_q;
  wire fall    = ~scl & scl_q;
  wire full    = bitcnt == 4'd8;
  wire [AW-1:0] nptr = ptr + AW'(1);
  wire in_clk  = ptr < CLK_END;
  wire shifting = (state == S_ADDR) | (state == S_PTR) | (state == S_WR) | (state == S_RD);
  wire wr_go   = ~pwr_fail & ~start_c & ~stop_c & fall & (state == S_WR) & full;

  assign snap_hold = sel & in_clk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl;
      sda_q  <= sda;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (wr_go) begin
      mem[ptr] <= (ptr == '0) ? 8'h00 : sreg;
      if (in_clk) mem[0] <= 8'h00;
    end else if (upd_valid && !snap_hold) begin
      for (int i = 0; i < NCLK; i++) mem[i] <= upd_time[i*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_we   <= 1'b0;
      set_addr <= '0;
      set_data <= 8'h00;
    end else begin
      set_we   <= wr_go & in_clk;
      set_addr <= ptr[CW-1:0];
      set_data <= (ptr == '0) ? 8'h00 : sreg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sreg   <= 8'h00;
      tx     <= 8'h00;
      bitcnt <= 4'd0;
      ptr    <= '0;
      rw     <= 1'b0;
      sel    <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (pwr_fail) begin
      state  <= S_IDLE;
      bitcnt <= 4'd0;
      ptr    <= '0;
      sel    <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      state  <= S_ADDR;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      sel    <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      if (rise && shifting && !full) begin
        sreg   <= {sreg[6:0], sda};
        bitcnt <= bitcnt + 4'd1;
      end
      if (rise && state == S_RACK) mack <= ~sda;
      if (fall) begin
        case (state)
          S_ADDR: if (full) begin
            if (sreg[7:1] == DEV_ADDR) begin
              sel    <= 1'b1;
              rw     <= sreg[0];
              sda_oe <= 1'b1;
              state  <= S_AACK;
            end else begin
              sel   <= 1'b0;
              state <= S_IDLE;
            end
          end
          S_AACK: begin
            bitcnt <= 4'd0;
            if (rw) begin
              tx     <= mem[ptr];
              sda_oe <= ~mem[ptr][7];
              state  <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_PTR;
            end
          end
          S_PTR: if (full) begin
            ptr    <= sreg[AW-1:0];
            sda_oe <= 1'b1;
            state  <= S_PACK;
          end
          S_PACK: begin
            sda_oe <= 1'b0;
            bitcnt <= 4'd0;
            state  <= S_WR;
          end
          S_WR: if (full) begin
            sda_oe <= 1'b1;
            state  <= S_WACK;
          end
          S_WACK: begin
            sda_oe <= 1'b0;
            bitcnt <= 4'd0;
            ptr    <= nptr;
            state  <= S_WR;
          end
          S_RD: begin
            if (full) begin
              sda_oe <= 1'b0;
              state  <= S_RACK;
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
          S_RACK: begin
            ptr    <= nptr;
            bitcnt <= 4'd0;
            if (mack) begin
              tx     <= mem[nptr];
              sda_oe <= ~mem[nptr][7];
              state  <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_i2c_target_chk.sv
module rtc_i2c_target_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_fail,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          snap_hold,
  input logic          set_we,
  input logic [CW-1:0] set_addr,
  input logic [7:0]    set_data
);
  a_r8_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (!sda_oe && !snap_hold));

  a_r6_subsec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && set_addr == '0) |-> set_data == 8'h00);

  a_r5_set_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |-> snap_hold);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> !set_we);

  a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(pwr_fail)) |-> !$past(scl_s));
endmodule

bind rtc_i2c_target rtc_i2c_target_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .scl_s(scl_sy[1]),
  .sda_oe(sda_oe), .snap_hold(snap_hold), .set_we(set_we),
  .set_addr(set_addr), .set_data(set_data)
);

// File: tb/rtc_i2c_target_tb.sv
module rtc_i2c_target_tb;
  localparam int Q = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, pwr_fail = 1'b0, upd_valid = 1'b0;
  logic [63:0] upd_time = '0;
  logic sda_oe, snap_hold, set_we;
  logic [2:0] set_addr;
  logic [7:0] set_data;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  rtc_i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .pwr_fail(pwr_fail),
    .upd_valid(upd_valid), .upd_time(upd_time), .sda_oe(sda_oe), .snap_hold(snap_hold),
    .set_we(set_we), .set_addr(set_addr), .set_data(set_data)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [10:0] wq[$];
  logic [7:0]  rq[$];
  logic [10:0] exp_w;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && set_we) begin
      if (wq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6 unexpected set pulse actual=%0h:%0h expected=none", set_addr, set_data);
      end else begin
        exp_w = wq.pop_front();
        chk("R6 clock set pulse", {5'b0, set_addr, set_data}, {5'b0, exp_w});
      end
    end
  end

  task automatic wq_(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq_(); scl_m = 1'b1; wq_(); sda_m = 1'b0; wq_(); scl_m = 1'b0; wq_();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq_(); scl_m = 1'b1; wq_(); sda_m = 1'b1; wq_(); wq_();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq_(); scl_m = 1'b1; wq_(); wq_(); scl_m = 1'b0; wq_();
  endtask

  task automatic wbyte(input logic [7:0] b, input logic exp_ack, input string req);
    logic ack;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq_(); scl_m = 1'b1; wq_();
    ack = ~sda_bus;
    wq_(); scl_m = 1'b0; wq_();
    chk(req, {15'b0, ack}, {15'b0, exp_ack});
  endtask

  task automatic rbyte(input logic give_ack, input string req);
    logic [7:0] v;
    logic b1, b2;
    logic stable_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq_(); scl_m = 1'b1; wq_();
      b1 = sda_bus; wq_(); b2 = sda_bus; scl_m = 1'b0; wq_();
      if (b1 !== b2) stable_ok = 1'b0;
      v[i] = b1;
    end
    send_bit(~give_ack);
    sda_m = 1'b1;
    chk("R9 data stable while SCL high", {15'b0, stable_ok}, 16'd1);
    if (rq.size() == 0) chk({req, " no expected byte"}, {8'b0, v}, 16'hffff);
    else chk(req, {8'b0, v}, {8'b0, rq.pop_front()});
  endtask

  task automatic open_read(input logic [7:0] p);
    bus_start();
    wbyte(8'hD0, 1'b1, "R1 address ack");
    wbyte(p, 1'b1, "R2 pointer ack");
    bus_start();
    wbyte(8'hD1, 1'b1, "R1 read address ack");
  endtask

  task automatic pulse_upd(input logic [63:0] t);
    upd_time = t; upd_valid = 1'b1; @(negedge clk); upd_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset sda_oe", {15'b0, sda_oe}, 16'd0);
    chk("R10 reset snap_hold", {15'b0, snap_hold}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 idle set_we", {15'b0, set_we}, 16'd0);

    // R1 foreign address is not acknowledged
    bus_start();
    wbyte(8'hA0, 1'b0, "R1 foreign address nack");
    wbyte(8'h10, 1'b0, "R1 bus ignored after foreign address");
    bus_stop();

    // R2 pointer plus sequential writes
    bus_start();
    wbyte(8'hD0, 1'b1, "R1 address ack");
    wbyte(8'h10, 1'b1, "R2 pointer ack");
    wbyte(8'hA5, 1'b1, "R2 data ack");
    wbyte(8'h3C, 1'b1, "R2 data ack");
    wbyte(8'h7E, 1'b1, "R2 data ack");
    bus_stop();

    // R3 sequential read, R7 NACK release
    open_read(8'h10);
    rq.push_back(8'hA5); rq.push_back(8'h3C);
    rbyte(1'b1, "R3 read 10h");
    rbyte(1'b0, "R3 read 11h");
    chk("R7 sda released after nack", {15'b0, sda_oe}, 16'd0);
    chk("R7 bus line high after nack", {15'b0, sda_bus}, 16'd1);
    bus_stop();

    // R4 current-address read resumes at 12h
    bus_start();
    wbyte(8'hD1, 1'b1, "R1 read address ack");
    rq.push_back(8'h7E);
    rbyte(1'b0, "R4 current address read");
    bus_stop();

    // R3 wrap from 3Fh to 00h, R6 byte 0 forced to 00h
    bus_start();
    wbyte(8'hD0, 1'b1, "R1 address ack");
    wbyte(8'h3F, 1'b1, "R2 pointer ack");
    wbyte(8'h11, 1'b1, "R2 data ack");
    wq.push_back({3'd0, 8'h00});
    wbyte(8'h22, 1'b1, "R2 data ack at 00h");
    bus_stop();
    open_read(8'h3F);
    rq.push_back(8'h11); rq.push_back(8'h00);
    rbyte(1'b1, "R3 read 3Fh");
    rbyte(1'b0, "R3 wrapped read 00h");
    bus_stop();

    // R5 snapshot hold
    pulse_upd(64'h0807060504030201);
    bus_start();
    wbyte(8'hD0, 1'b1, "R1 address ack");
    wbyte(8'h00, 1'b1, "R2 pointer ack");
    chk("R5 hold in clock range", {15'b0, snap_hold}, 16'd1);
    bus_start();
    wbyte(8'hD1, 1'b1, "R1 read address ack");
    rq.push_back(8'h01);
    rbyte(1'b1, "R5 frozen byte 0");
    pulse_upd(64'h9897969594939291);
    for (int i = 1; i < 8; i++) begin
      rq.push_back(8'(i + 1));
      rbyte(1'b1, "R5 frozen clock byte");
    end
    rq.push_back(8'h00);
    rbyte(1'b0, "R5 control byte 08h");
    chk("R5 hold drops past 07h", {15'b0, snap_hold}, 16'd0);
    bus_stop();
    pulse_upd(64'h9897969594939291);
    open_read(8'h03);
    chk("R5 hold on pointer 03h", {15'b0, snap_hold}, 16'd1);
    rq.push_back(8'h94);
    rbyte(1'b0, "R5 update taken when free");
    bus_stop();
    chk("R5 hold released by stop", {15'b0, snap_hold}, 16'd0);

    // R6 clock writes
    bus_start();
    wbyte(8'hD0, 1'b1, "R1 address ack");
    wbyte(8'h00, 1'b1, "R2 pointer ack");
    wq.push_back({3'd0, 8'h00});
    wbyte(8'h99, 1'b1, "R6 write 00h ack");
    wq.push_back({3'd1, 8'h5A});
    wbyte(8'h5A, 1'b1, "R6 write 01h ack");
    wq.push_back({3'd2, 8'h45});
    wbyte(8'h45, 1'b1, "R6 write 02h ack");
    bus_stop();
    open_read(8'h00);
    rq.push_back(8'h00); rq.push_back(8'h5A); rq.push_back(8'h45);
    rbyte(1'b1, "R6 sub-second stays 00h");
    rbyte(1'b1, "R6 stored 01h");
    rbyte(1'b0, "R6 stored 02h");
    bus_stop();

    // R8 power-fail abort
    bus_start();
    wbyte(8'hD0, 1'b1, "R1 address ack");
    wbyte(8'h02, 1'b1, "R2 pointer ack");
    chk("R8 hold before abort", {15'b0, snap_hold}, 16'd1);
    @(negedge clk); pwr_fail = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 sda released on abort", {15'b0, sda_oe}, 16'd0);
    chk("R8 hold dropped on abort", {15'b0, snap_hold}, 16'd0);
    bus_stop();
    bus_start();
    wbyte(8'hD0, 1'b0, "R8 no ack during power fail");
    bus_stop();
    pwr_fail = 1'b0;
    repeat (2) @(negedge clk);
    bus_start();
    wbyte(8'hD1, 1'b1, "R1 read address ack");
    rq.push_back(8'h00);
    rbyte(1'b0, "R8 pointer reset to 00h");
    bus_stop();

    repeat (4) @(negedge clk);
    chk("R6 all set pulses seen", 16'(wq.size()), 16'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule